// File: doc/BRIEF.md
# System Control Register Bank

This block is a 4 KB window of control and status words for a small embedded subsystem. It holds the reset, boot and power-control state. A simple single-cycle request port reaches it, and a registered response comes back one cycle later. Software uses it for several jobs:
- set and clear secure-debug enables through separate set and clear aliases,
- inspect and mask reset causes,
- keep one word across system resets,
- place boot vectors for two cores,
- hold either core in wait and later release it.

Several words are placeholders for clock dividers, power-domain sense and wakeup control. They are stored and read back, but nothing else in the block uses them.

Three kinds of output leave the block: a one-cycle system reset request, a one-cycle release pulse for each core, and the two boot vectors. A static parameter selects the extended map or the basic map. In the basic map, the words that only the extended map has behave as unmapped, and the NMI-enable word reads as zero and cannot be written. An error flag pulses for one cycle on any access the map does not allow. That covers an unmapped offset, a write to a read-only word, and a read of a write-only word.

Top module: `sysctl_regbank`

## Requirements
- R1: After reset these words read as follows: reset syndrome (0x100) reads 1, system power sense (0x200) reads 0x7F, both boot vectors (0x110, 0x114) read 0x10000000 and are driven on the vector outputs, CPU wait (0x118) reads 0, and every other stored word reads 0.
- R2: A read presents `rsp_valid` and `rsp_rdata` on the cycle after the request. Plain storage words return the last value written. In the extended map those words are 0x00C, 0x010, 0x014, 0x018, 0x104, 0x10C, 0x11C, 0x120, 0x124, 0x200, 0x20C, 0x210, 0x214 and 0x218.
- R3: A write to 0x004 ORs the data into the debug word. A write to 0x008 clears the bits that are written as 1. Word 0x000 returns the debug word and ignores writes.
- R4: A write to 0x108 with bit 9 set gives a one-cycle `sys_reset_req` on the cycle after the write. Other bits give no pulse. Reads of 0x004, 0x008 and 0x108 return 0.
- R5: A write to 0x118 stores the new value. For each core i in {0,1}, bit i going from 1 to 0 gives a one-cycle pulse on `core_release[i]` on the cycle after the write.
- R6: `boot_vec0` and `boot_vec1` show words 0x110 and 0x114 from the cycle after a write to them.
- R7: Words 0xFD0 to 0xFFC read, in address order, 0x04, 0x00, 0x00, 0x00, 0x54, 0xB8, 0x0B, 0x00, 0x0D, 0xF0, 0x05, 0xB1. Writes to them change nothing.
- R8: In the basic map (`EXTENDED`=0), the following words read 0 and drop writes: 0x00C, 0x010, 0x014, 0x018, 0x114, 0x124, 0x200, 0x20C, 0x210, 0x214 and 0x218. Word 0x11C reads 0 and is read-only.
- R9: `req_size` 0 means byte, 1 means halfword, and 2 or 3 mean word. A narrow write stores only the low 8 or 16 data bits, with the rest zero. A narrow read returns the low 8 or 16 bits of the word, zero-extended. Address bits 1:0 are ignored.
- R10: `acc_err` pulses for one cycle, on the cycle after the request, for these accesses: an unmapped offset, a write to 0x000, a write to the ID area, a write to 0x11C in the basic map, or a read of 0x004, 0x008 or 0x108. A read that errors returns 0.
- R11: Word 0x10C keeps its value through `rst`. Only `por` clears it.
- R12: An offset with no word (for example 0x300) reads 0 and drops writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous system reset, active high; spares the retention word |
| por | input | 1 | Synchronous power-on reset, active high; clears everything |
| req_valid | input | 1 | Access request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 2 | 0 byte, 1 halfword, 2/3 word |
| req_addr | input | 12 | Byte offset in the 4 KB window |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid, one cycle after a read |
| rsp_rdata | output | 32 | Read data |
| acc_err | output | 1 | One-cycle flag for a disallowed access |
| sys_reset_req | output | 1 | One-cycle system reset request |
| core_release | output | 2 | One-cycle release pulse per core |
| boot_vec0 | output | 32 | Boot vector of core 0 |
| boot_vec1 | output | 32 | Boot vector of core 1 |

## Verification
The assertions assume that a request lasts exactly one cycle and that both resets are held at the start. They also assume that `por` and `rst` are never asserted while a request is in flight. The stimulus follows these rules: every access is driven for one cycle from the falling edge and then dropped, and the resets are pulsed only between accesses. Random full-word writes and read-backs cover every storage word of both maps, and a basic-map instance shares the same bus. Directed sequences cover the alias, pulse, narrow-access and ID-area cases.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;

    localparam int DW     = 32;
    localparam int NCORE  = 2;
    localparam int AW     = 12;
    localparam int WORD_W = AW - 2;

    typedef enum logic [4:0] {
        ID_NONE, ID_DBG_STAT, ID_DBG_SET, ID_DBG_CLR, ID_SECCTL,
        ID_MCLKDIV, ID_SCLKDIV, ID_CLKFORCE, ID_RSTSYN, ID_RSTMASK,
        ID_SWRST, ID_RETAIN, ID_BOOT0, ID_BOOT1, ID_CPUWAIT,
        ID_NMIEN, ID_WAKECTL, ID_EXTWAKE, ID_PDSYS, ID_PDM0,
        ID_PDM1, ID_PDM2, ID_PDM3, ID_IDAREA
    } reg_id_e;

    localparam int NUM_IDS = 24;

    typedef struct packed {
        reg_id_e id;
        logic    rd_ok;
        logic    wr_ok;
        logic    rd_zero;
    } dec_t;

    typedef struct packed {
        logic              valid;
        logic              write;
        logic [1:0]        size;
        logic [WORD_W-1:0] word;
        logic [DW-1:0]     wdata;
    } req_t;

    localparam logic [DW-1:0]     SWRST_MASK = 32'h0000_0200;
    localparam logic [WORD_W-1:0] ID_BASE    = 10'h3F4;

    function automatic logic [DW-1:0] lane_mask(input logic [1:0] size);
        case (size)
            2'd0:    return 32'h0000_00FF;
            2'd1:    return 32'h0000_FFFF;
            default: return 32'hFFFF_FFFF;
        endcase
    endfunction

    function automatic logic [DW-1:0] id_word(input logic [3:0] idx);
        case (idx)
            4'd0:  return 32'h04;
            4'd4:  return 32'h54;
            4'd5:  return 32'hB8;
            4'd6:  return 32'h0B;
            4'd8:  return 32'h0D;
            4'd9:  return 32'hF0;
            4'd10: return 32'h05;
            4'd11: return 32'hB1;
            default: return 32'h00;
        endcase
    endfunction

    function automatic dec_t mk(input reg_id_e id, input logic r,
                                input logic w, input logic z);
        dec_t d;
        d.id = id; d.rd_ok = r; d.wr_ok = w; d.rd_zero = z;
        return d;
    endfunction

    function automatic dec_t decode_word(input logic [WORD_W-1:0] w,
                                         input logic ext);
        dec_t none;
        none = mk(ID_NONE, 1'b0, 1'b0, 1'b0);
        if (w >= ID_BASE) return mk(ID_IDAREA, 1'b1, 1'b0, 1'b0);
        case (w)
            10'h000: return mk(ID_DBG_STAT, 1'b1, 1'b0, 1'b0);
            10'h001: return mk(ID_DBG_SET,  1'b0, 1'b1, 1'b0);
            10'h002: return mk(ID_DBG_CLR,  1'b0, 1'b1, 1'b0);
            10'h003: return ext ? mk(ID_SECCTL,   1'b1, 1'b1, 1'b0) : none;
            10'h004: return ext ? mk(ID_MCLKDIV,  1'b1, 1'b1, 1'b0) : none;
            10'h005: return ext ? mk(ID_SCLKDIV,  1'b1, 1'b1, 1'b0) : none;
            10'h006: return ext ? mk(ID_CLKFORCE, 1'b1, 1'b1, 1'b0) : none;
            10'h040: return mk(ID_RSTSYN,  1'b1, 1'b1, 1'b0);
            10'h041: return mk(ID_RSTMASK, 1'b1, 1'b1, 1'b0);
            10'h042: return mk(ID_SWRST,   1'b0, 1'b1, 1'b0);
            10'h043: return mk(ID_RETAIN,  1'b1, 1'b1, 1'b0);
            10'h044: return mk(ID_BOOT0,   1'b1, 1'b1, 1'b0);
            10'h045: return ext ? mk(ID_BOOT1, 1'b1, 1'b1, 1'b0) : none;
            10'h046: return mk(ID_CPUWAIT, 1'b1, 1'b1, 1'b0);
            10'h047: return mk(ID_NMIEN,   1'b1, ext, !ext);
            10'h048: return mk(ID_WAKECTL, 1'b1, 1'b1, 1'b0);
            10'h049: return ext ? mk(ID_EXTWAKE, 1'b1, 1'b1, 1'b0) : none;
            10'h080: return ext ? mk(ID_PDSYS, 1'b1, 1'b1, 1'b0) : none;
            10'h083: return ext ? mk(ID_PDM0,  1'b1, 1'b1, 1'b0) : none;
            10'h084: return ext ? mk(ID_PDM1,  1'b1, 1'b1, 1'b0) : none;
            10'h085: return ext ? mk(ID_PDM2,  1'b1, 1'b1, 1'b0) : none;
            10'h086: return ext ? mk(ID_PDM3,  1'b1, 1'b1, 1'b0) : none;
            default: return none;
        endcase
    endfunction

endpackage

// File: rtl/sysctl_decode.sv
module sysctl_decode
    import sysctl_pkg::*;
#(
    parameter bit EXTENDED = 1'b1
) (
    input  logic [WORD_W-1:0] word,
    output dec_t              dec
);
    always_comb dec = decode_word(word, EXTENDED);
endmodule

// File: rtl/sysctl_regfile.sv
module sysctl_regfile
    import sysctl_pkg::*;
#(
    parameter logic [DW-1:0] BOOT0_RST = 32'h1000_0000,
    parameter logic [DW-1:0] BOOT1_RST = 32'h1000_0000,
    parameter logic [DW-1:0] WAIT_RST  = 32'h0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             por,
    input  req_t             req,
    input  dec_t             dec,
    output logic [DW-1:0]    rd_word,
    output logic             srst_pulse,
    output logic [NCORE-1:0] rel_pulse,
    output logic [DW-1:0]    boot0,
    output logic [DW-1:0]    boot1
);
    logic [DW-1:0]    store_q [NUM_IDS];
    logic [DW-1:0]    wd;
    logic             wr_en;
    logic             srst_q;
    logic [NCORE-1:0] rel_q;

    assign wd    = req.wdata & lane_mask(req.size);
    assign wr_en = req.valid & req.write & dec.wr_ok;

    function automatic logic [DW-1:0] rst_val(input int k);
        case (k)
            int'(ID_RSTSYN):  return 32'h1;
            int'(ID_PDSYS):   return 32'h7F;
            int'(ID_BOOT0):   return BOOT0_RST;
            int'(ID_BOOT1):   return BOOT1_RST;
            int'(ID_CPUWAIT): return WAIT_RST;
            default:          return '0;
        endcase
    endfunction

    always_ff @(posedge clk) begin
        srst_q <= 1'b0;
        rel_q  <= '0;
        if (por || rst) begin
            for (int k = 0; k < NUM_IDS; k++) begin
                if (por || k != int'(ID_RETAIN)) store_q[k] <= rst_val(k);
            end
        end else if (wr_en) begin
            case (dec.id)
                ID_DBG_SET: store_q[ID_DBG_STAT] <= store_q[ID_DBG_STAT] | wd;
                ID_DBG_CLR: store_q[ID_DBG_STAT] <= store_q[ID_DBG_STAT] & ~wd;
                ID_SWRST:   srst_q <= |(wd & SWRST_MASK);
                ID_CPUWAIT: begin
                    rel_q <= store_q[ID_CPUWAIT][NCORE-1:0] & ~wd[NCORE-1:0];
                    store_q[ID_CPUWAIT] <= wd;
                end
                default:    store_q[dec.id] <= wd;
            endcase
        end
    end

    assign rd_word    = store_q[dec.id];
    assign srst_pulse = srst_q;
    assign rel_pulse  = rel_q;
    assign boot0      = store_q[ID_BOOT0];
    assign boot1      = store_q[ID_BOOT1];

    generate
        for (genvar c = 0; c < NCORE; c++) begin : g_rel_chk
            // R5
            release_clears_chk: assert property (@(posedge clk) disable iff (rst || por)
                rel_q[c] |-> !store_q[ID_CPUWAIT][c]);
            // R5
            release_was_set_chk: assert property (@(posedge clk) disable iff (rst || por)
                rel_q[c] |-> $past(store_q[ID_CPUWAIT][c]));
        end
    endgenerate

    // R3
    dbg_set_chk: assert property (@(posedge clk) disable iff (rst || por)
        (wr_en && dec.id == ID_DBG_SET) |=>
            ((store_q[ID_DBG_STAT] & $past(wd)) == $past(wd)));

    // R11
    retain_hold_chk: assert property (@(posedge clk)
        (rst && !por) |=> store_q[ID_RETAIN] == $past(store_q[ID_RETAIN]));
endmodule

// File: rtl/sysctl_rdpath.sv
module sysctl_rdpath
    import sysctl_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          por,
    input  req_t          req,
    input  dec_t          dec,
    input  logic [DW-1:0] rd_word,
    output logic          rsp_valid,
    output logic [DW-1:0] rsp_rdata,
    output logic          acc_err
);
    logic [DW-1:0] raw;
    logic          is_rd;
    logic          bad;
    logic [3:0]    id_idx;

    assign id_idx = req.word[3:0] - ID_BASE[3:0];
    assign is_rd  = req.valid & ~req.write;
    assign bad    = req.valid & (req.write ? ~dec.wr_ok : ~dec.rd_ok);

    always_comb begin
        if (!dec.rd_ok || dec.rd_zero) raw = '0;
        else if (dec.id == ID_IDAREA)  raw = id_word(id_idx);
        else                           raw = rd_word;
    end

    always_ff @(posedge clk) begin
        if (rst || por) begin
            rsp_valid <= 1'b0;
            rsp_rdata <= '0;
            acc_err   <= 1'b0;
        end else begin
            rsp_valid <= is_rd;
            rsp_rdata <= is_rd ? (raw & lane_mask(req.size)) : '0;
            acc_err   <= bad;
        end
    end

    // R10
    err_read_zero_chk: assert property (@(posedge clk) disable iff (rst || por)
        (rsp_valid && acc_err) |-> rsp_rdata == '0);
    // R10
    err_needs_req_chk: assert property (@(posedge clk) disable iff (rst || por)
        acc_err |-> $past(req.valid));
endmodule

// File: rtl/sysctl_regbank.sv
module sysctl_regbank
    import sysctl_pkg::*;
#(
    parameter bit            EXTENDED  = 1'b1,
    parameter logic [31:0]   BOOT0_RST = 32'h1000_0000,
    parameter logic [31:0]   BOOT1_RST = 32'h1000_0000,
    parameter logic [31:0]   WAIT_RST  = 32'h0
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        por,
    input  logic        req_valid,
    input  logic        req_write,
    input  logic [1:0]  req_size,
    input  logic [11:0] req_addr,
    input  logic [31:0] req_wdata,
    output logic        rsp_valid,
    output logic [31:0] rsp_rdata,
    output logic        acc_err,
    output logic        sys_reset_req,
    output logic [1:0]  core_release,
    output logic [31:0] boot_vec0,
    output logic [31:0] boot_vec1
);
    req_t          req;
    dec_t          dec;
    logic [DW-1:0] rd_word;
    logic          unused_lsb;

    assign unused_lsb = ^req_addr[1:0];
    assign req.valid  = req_valid;
    assign req.write  = req_write;
    assign req.size   = req_size;
    assign req.word   = req_addr[AW-1:2];
    assign req.wdata  = req_wdata;

    sysctl_decode #(.EXTENDED(EXTENDED)) u_dec (
        .word(req.word), .dec(dec)
    );

    sysctl_regfile #(
        .BOOT0_RST(BOOT0_RST), .BOOT1_RST(BOOT1_RST), .WAIT_RST(WAIT_RST)
    ) u_regs (
        .clk(clk), .rst(rst), .por(por), .req(req), .dec(dec),
        .rd_word(rd_word), .srst_pulse(sys_reset_req),
        .rel_pulse(core_release), .boot0(boot_vec0), .boot1(boot_vec1)
    );

    sysctl_rdpath u_rd (
        .clk(clk), .rst(rst), .por(por), .req(req), .dec(dec),
        .rd_word(rd_word), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .acc_err(acc_err)
    );

    // R4
    sysreset_from_write_chk: assert property (@(posedge clk) disable iff (rst || por)
        sys_reset_req |-> $past(req_valid && req_write));
endmodule

// File: tb/tb_sysctl_regbank.sv
`timescale 1ns/1ps
module tb_sysctl_regbank;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        por = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [1:0]  req_size = 2'd2;
    logic [11:0] req_addr = '0;
    logic [31:0] req_wdata = '0;

    logic        e_vld, e_err, e_srst, b_vld, b_err, b_srst;
    logic [31:0] e_data, e_b0, e_b1, b_data, b_b0, b_b1;
    logic [1:0]  e_rel, b_rel;

    int nchk = 0;
    int nerr = 0;
    bit finished = 1'b0;

    logic [31:0] ge_data, gb_data;
    logic        ge_err, gb_err, ge_srst, ge_vld;
    logic [1:0]  ge_rel;

    always #2 clk = ~clk;

    sysctl_regbank #(.EXTENDED(1'b1)) dut (
        .clk(clk), .rst(rst), .por(por), .req_valid(req_valid),
        .req_write(req_write), .req_size(req_size), .req_addr(req_addr),
        .req_wdata(req_wdata), .rsp_valid(e_vld), .rsp_rdata(e_data),
        .acc_err(e_err), .sys_reset_req(e_srst), .core_release(e_rel),
        .boot_vec0(e_b0), .boot_vec1(e_b1));

    sysctl_regbank #(.EXTENDED(1'b0)) dut_basic (
        .clk(clk), .rst(rst), .por(por), .req_valid(req_valid),
        .req_write(req_write), .req_size(req_size), .req_addr(req_addr),
        .req_wdata(req_wdata), .rsp_valid(b_vld), .rsp_rdata(b_data),
        .acc_err(b_err), .sys_reset_req(b_srst), .core_release(b_rel),
        .boot_vec0(b_b0), .boot_vec1(b_b1));

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic access(input bit wr, input logic [11:0] a,
                          input logic [31:0] d, input logic [1:0] sz);
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = a;
        req_wdata = d; req_size = sz;
        @(negedge clk);
        ge_data = e_data; gb_data = b_data; ge_err = e_err; gb_err = b_err;
        ge_srst = e_srst; ge_rel = e_rel; ge_vld = e_vld;
        req_valid = 1'b0;
    endtask

    task automatic pulse_reset(input bit power_on);
        @(negedge clk);
        rst = 1'b1; por = power_on;
        @(negedge clk);
        rst = 1'b0; por = 1'b0;
    endtask

    // storage words common to both maps and extended-only ones
    function automatic logic [11:0] off_of(input int i);
        case (i)
            0: return 12'h00C;  1: return 12'h010;  2: return 12'h014;
            3: return 12'h018;  4: return 12'h104;  5: return 12'h10C;
            6: return 12'h11C;  7: return 12'h120;  8: return 12'h124;
            9: return 12'h200;  10: return 12'h20C; 11: return 12'h210;
            12: return 12'h214; default: return 12'h218;
        endcase
    endfunction

    function automatic bit ext_only(input int i);
        return !(i == 4 || i == 5 || i == 6 || i == 7);
    endfunction

    function automatic logic [31:0] exp_id(input int k);
        case (k)
            0: return 32'h04; 4: return 32'h54; 5: return 32'hB8; 6: return 32'h0B;
            8: return 32'h0D; 9: return 32'hF0; 10: return 32'h05; 11: return 32'hB1;
            default: return 32'h00;
        endcase
    endfunction

    function automatic logic [31:0] narrow(input logic [31:0] v, input logic [1:0] sz);
        return (sz == 2'd0) ? (v & 32'hFF) : (sz == 2'd1) ? (v & 32'hFFFF) : v;
    endfunction

    logic [31:0] model_e [14];
    logic [31:0] model_b [14];

    initial begin
        void'($urandom(32'd7321));
        repeat (3) @(negedge clk);
        rst = 1'b0; por = 1'b0;

        // R1 reset values
        access(1'b0, 12'h100, 0, 2'd2); check("R1 syndrome", ge_data, 32'h1);
        check("R2 rsp_valid", {31'b0, ge_vld}, 32'h1);
        access(1'b0, 12'h200, 0, 2'd2); check("R1 pd sense", ge_data, 32'h7F);
        access(1'b0, 12'h118, 0, 2'd2); check("R1 cpuwait", ge_data, 32'h0);
        access(1'b0, 12'h114, 0, 2'd2); check("R1 boot1 reg", ge_data, 32'h1000_0000);
        check("R1 boot0 out", e_b0, 32'h1000_0000);
        check("R1 boot1 out", e_b1, 32'h1000_0000);
        access(1'b0, 12'h000, 0, 2'd2); check("R1 debug", ge_data, 32'h0);

        // R3 debug aliases
        access(1'b1, 12'h004, 32'h0F0, 2'd2);
        access(1'b1, 12'h004, 32'h003, 2'd2);
        access(1'b0, 12'h000, 0, 2'd2); check("R3 set", ge_data, 32'h0F3);
        access(1'b1, 12'h008, 32'h030, 2'd2);
        access(1'b0, 12'h000, 0, 2'd2); check("R3 clear", ge_data, 32'h0C3);
        access(1'b1, 12'h000, 32'hFFFF_FFFF, 2'd2); check("R10 write status err", {31'b0, ge_err}, 1);
        access(1'b0, 12'h000, 0, 2'd2); check("R3 status read-only", ge_data, 32'h0C3);
        access(1'b0, 12'h004, 0, 2'd2); check("R4 read set alias", ge_data, 0);
        check("R10 read WO err", {31'b0, ge_err}, 1);
        access(1'b0, 12'h008, 0, 2'd2); check("R4 read clr alias", ge_data, 0);

        // R4 software reset
        access(1'b1, 12'h108, 32'h200, 2'd2); check("R4 pulse", {31'b0, ge_srst}, 1);
        @(negedge clk); check("R4 one cycle", {31'b0, e_srst}, 0);
        access(1'b1, 12'h108, 32'hFFFF_FDFF, 2'd2); check("R4 no pulse", {31'b0, ge_srst}, 0);
        access(1'b0, 12'h108, 0, 2'd2); check("R4 read zero", ge_data, 0);

        // R5 core release
        access(1'b1, 12'h118, 32'h3, 2'd2); check("R5 set no pulse", {30'b0, ge_rel}, 0);
        access(1'b1, 12'h118, 32'h2, 2'd2); check("R5 core0", {30'b0, ge_rel}, 1);
        @(negedge clk); check("R5 one cycle", {30'b0, e_rel}, 0);
        access(1'b1, 12'h118, 32'h0, 2'd2); check("R5 core1", {30'b0, ge_rel}, 2);
        access(1'b1, 12'h118, 32'h0, 2'd2); check("R5 no repeat", {30'b0, ge_rel}, 0);
        access(1'b0, 12'h118, 0, 2'd2); check("R5 stored", ge_data, 0);

        // R6 boot vectors
        access(1'b1, 12'h110, 32'hDEAD_0000, 2'd2); check("R6 boot0", e_b0, 32'hDEAD_0000);
        access(1'b1, 12'h114, 32'hBEEF_0100, 2'd2); check("R6 boot1", e_b1, 32'hBEEF_0100);
        check("R8 basic boot1 dropped", b_b1, 32'h1000_0000);
        check("R8 basic boot1 err", {31'b0, gb_err}, 1);

        // R7 ID area
        for (int k = 0; k < 12; k++) begin
            access(1'b0, 12'hFD0 + 12'(4 * k), 0, 2'd2);
            check($sformatf("R7 id %0d", k), ge_data, exp_id(k));
        end
        access(1'b1, 12'hFE0, 32'h1234, 2'd2); check("R10 write id err", {31'b0, ge_err}, 1);
        access(1'b0, 12'hFE0, 0, 2'd2); check("R7 id unchanged", ge_data, 32'h54);

        // R9 narrow accesses
        access(1'b1, 12'h120, 32'hAABB_CCDD, 2'd0);
        access(1'b0, 12'h120, 0, 2'd2); check("R9 byte write", ge_data, 32'hDD);
        access(1'b1, 12'h121, 32'h1234_5678, 2'd1);
        access(1'b0, 12'h120, 0, 2'd3); check("R9 half write", ge_data, 32'h5678);
        access(1'b1, 12'h120, 32'hCAFE_F00D, 2'd2);
        access(1'b0, 12'h120, 0, 2'd0); check("R9 byte read", ge_data, 32'h0D);
        access(1'b0, 12'h122, 0, 2'd1); check("R9 half read", ge_data, 32'hF00D);

        // R12 unknown offsets
        access(1'b1, 12'h300, 32'h5555, 2'd2); check("R12 write err", {31'b0, ge_err}, 1);
        access(1'b0, 12'h300, 0, 2'd2); check("R12 read zero", ge_data, 0);
        check("R10 unmapped read err", {31'b0, ge_err}, 1);

        // R2 / R8 random storage traffic
        for (int i = 0; i < 14; i++) begin
            access(1'b0, off_of(i), 0, 2'd2);
            model_e[i] = ge_data; model_b[i] = gb_data;
        end
        for (int n = 0; n < 120; n++) begin
            int i;
            logic [31:0] d;
            i = int'($urandom % 14);
            d = $urandom;
            access(1'b1, off_of(i), d, 2'd2);
            check("R8 basic write err", {31'b0, gb_err}, {31'b0, ext_only(i) || i == 6});
            check("R10 good write no err", {31'b0, ge_err}, 0);
            model_e[i] = d;
            if (!ext_only(i) && i != 6) model_b[i] = d;
            access(1'b0, off_of(i), 0, 2'd2);
            check("R2 readback", ge_data, model_e[i]);
            check("R8 basic read", gb_data, (ext_only(i) || i == 6) ? 32'h0 : model_b[i]);
            check("R8 basic read err", {31'b0, gb_err}, {31'b0, ext_only(i)});
        end

        // R11 retention
        access(1'b1, 12'h10C, 32'h55AA, 2'd2);
        access(1'b1, 12'h100, 32'h8, 2'd2);
        pulse_reset(1'b0);
        access(1'b0, 12'h10C, 0, 2'd2); check("R11 kept over rst", ge_data, 32'h55AA);
        access(1'b0, 12'h100, 0, 2'd2); check("R1 syndrome after rst", ge_data, 32'h1);
        pulse_reset(1'b1);
        access(1'b0, 12'h10C, 0, 2'd2); check("R11 cleared by por", ge_data, 0);

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!finished) begin
            nchk++; nerr++;
            $display("FAIL watchdog: actual=timeout expected=done");
            $display("Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    end
endmodule